// File: doc/BRIEF.md
# Two-Wire Register Array with Potentiometer Wiper Outputs

This block is a two-wire serial slave that fronts a 256-location byte array. Most of the array is plain storage. Two locations feed the wiper codes of two digital potentiometers: one potentiometer has 100 steps and the other has 256. A controller on the bus selects the device with a 7-bit address. The top four bits of that address are fixed and the low three come from strap pins, so eight devices can share one bus. After the address, the controller loads a byte pointer, then streams bytes in or out. The pointer advances after every data byte.

The block samples both bus lines on its own system clock and finds START, STOP and the clock edges from the synchronised copies. The SDA output is an open-drain enable, so the block can only pull the line low. A single protect input freezes the storage and both wipers. Any value on that input other than a definite 0 counts as protected. The top six locations are reserved.

Top module: `pot_mem_top`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1010b followed by `strap_i[2:0]`. Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R2: Incoming bits are taken while SCL is high. Every change of `sda_oe_o` follows a falling SCL edge. After an acknowledge bit the block releases SDA, so the controller's next data bits reach the line unchanged.
- R3: In a write transfer, the first data byte loads the pointer. Each following byte is stored at the pointer, and the pointer then advances by one.
- R4: In a read transfer, the byte at the pointer is shifted out MSB first and the pointer advances. A controller acknowledge (SDA low) fetches the next byte. A repeated START keeps the pointer.
- R5: The pointer wraps from FFh to 00h, for reads and for writes.
- R6: Location F9h drives `wiper0_o` and location F8h drives `wiper1_o`. A write to either location reaches the output, and both locations read back their stored value.
- R7: A value above 99 (63h) written to F9h is stored as 99 and drives 99 on `wiper0_o`.
- R8: Locations FAh to FFh ignore writes and read as 00h.
- R9: While `wp_i` is anything other than 0, no write changes the array or either wiper. Data bytes are still acknowledged and the pointer still loads and advances.
- R10: A controller not-acknowledge ends a read. The block releases SDA and drives nothing more until the next START.
- R11: A STOP returns the block to idle with SDA released.
- R12: Reset clears both wipers to 0, clears the pointer to 00h and releases SDA. Storage locations 00h to F7h keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Device address straps |
| wp_i | input | 1 | Write protect; anything but 0 protects |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper0_o | output | 8 | Wiper code, 100-step potentiometer |
| wiper1_o | output | 8 | Wiper code, 256-step potentiometer |

## Verification
Each bus line passes two synchroniser stages and one edge-detect register before it reaches the transfer logic. `sda_oe_o` therefore moves three system clocks after the SCL edge that causes it. The bench holds every SCL phase for twelve clocks and samples SDA six clocks into the high phase, well after any such change has settled. A wiper changes one clock after the falling edge that ends its data byte. The bench reads the wiper ports only after the acknowledge bit and the STOP that follow, so it never samples a wiper inside its update window.

// File: rtl/pot_mem_pkg.sv
package pot_mem_pkg;
    localparam int BYTE_W      = 8;
    localparam int BIT_CNT_W   = $clog2(BYTE_W);
    localparam int STRAP_W     = 3;
    localparam int ARRAY_DEPTH = 256;
    localparam int PTR_W       = $clog2(ARRAY_DEPTH);
    localparam int RSVD_COUNT  = 6;
    localparam int USER_DEPTH  = ARRAY_DEPTH - RSVD_COUNT - 2;

    localparam logic [3:0]       DEV_FAMILY = 4'b1010;
    localparam logic [PTR_W-1:0] USER_LAST  = PTR_W'(USER_DEPTH - 1);
    localparam logic [PTR_W-1:0] WIPER1_LOC = PTR_W'(USER_DEPTH);
    localparam logic [PTR_W-1:0] WIPER0_LOC = PTR_W'(USER_DEPTH + 1);
    localparam logic [BYTE_W-1:0] WIPER0_MAX = BYTE_W'(99);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } link_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] clamp_w0(input logic [BYTE_W-1:0] v);
        return (v > WIPER0_MAX) ? WIPER0_MAX : v;
    endfunction
endpackage

// File: rtl/pot_mem_line_sync.sv
module pot_mem_line_sync
    import pot_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt_o
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_comb begin
        evt_o.sda      = sda_s;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.start    = scl_s & scl_q & ~sda_s & sda_q;
        evt_o.stop     = scl_s & scl_q & sda_s & ~sda_q;
    end
endmodule

// File: rtl/pot_mem_link.sv
module pot_mem_link
    import pot_mem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  line_evt_t          evt_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               sda_oe_o,
    output logic [PTR_W-1:0]   ptr_o,
    output wr_req_t            wr_o
);
    link_state_e          state;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]    sh;
    logic [PTR_W-1:0]     ptr;
    logic first_q, nack_q, rw_q, full_q, oe_q;
    wr_req_t wr_q;

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            ptr     <= '0;
            first_q <= 1'b0;
            nack_q  <= 1'b0;
            rw_q    <= 1'b0;
            full_q  <= 1'b0;
            oe_q    <= 1'b0;
            wr_q    <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (evt_i.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                full_q <= 1'b0;
                oe_q   <= 1'b0;
            end else if (evt_i.stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (evt_i.scl_rise) begin
                            sh     <= {sh[BYTE_W-2:0], evt_i.sda};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) full_q <= 1'b1;
                        end else if (evt_i.scl_fall && full_q) begin
                            full_q <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (sh[BYTE_W-1:1] == {DEV_FAMILY, strap_i}) begin
                                    oe_q    <= 1'b1;
                                    rw_q    <= sh[0];
                                    first_q <= 1'b1;
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                oe_q  <= 1'b1;
                                state <= ST_WR_ACK;
                                if (first_q) begin
                                    ptr     <= sh;
                                    first_q <= 1'b0;
                                end else begin
                                    wr_q.en   <= 1'b1;
                                    wr_q.addr <= ptr;
                                    wr_q.data <= sh;
                                    ptr       <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt_i.scl_fall) begin
                            bitcnt <= '0;
                            if (rw_q) begin
                                sh    <= rd_data_i;
                                oe_q  <= ~rd_data_i[BYTE_W-1];
                                state <= ST_RD;
                            end else begin
                                oe_q  <= 1'b0;
                                state <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt_i.scl_fall) begin
                            oe_q   <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (evt_i.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                oe_q  <= 1'b0;
                                ptr   <= ptr + 1'b1;
                                state <= ST_RD_ACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                oe_q   <= ~sh[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt_i.scl_rise) begin
                            nack_q <= evt_i.sda;
                        end else if (evt_i.scl_fall) begin
                            if (!nack_q) begin
                                sh     <= rd_data_i;
                                oe_q   <= ~rd_data_i[BYTE_W-1];
                                bitcnt <= '0;
                                state  <= ST_RD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = oe_q;
    assign ptr_o    = ptr;
    assign wr_o     = wr_q;
endmodule

// File: rtl/pot_mem_array.sv
module pot_mem_array
    import pot_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              protect_i,
    input  wr_req_t           wr_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [BYTE_W-1:0] wiper0_o,
    output logic [BYTE_W-1:0] wiper1_o
);
    logic [BYTE_W-1:0] user_mem [USER_DEPTH];
    logic [BYTE_W-1:0] w0_q, w1_q;
    logic wr_ok;

    assign wr_ok = wr_i.en & ~protect_i;

    always_ff @(posedge clk) begin
        if (wr_ok && wr_i.addr <= USER_LAST) user_mem[wr_i.addr] <= wr_i.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w0_q <= '0;
            w1_q <= '0;
        end else if (wr_ok) begin
            if (wr_i.addr == WIPER0_LOC) w0_q <= clamp_w0(wr_i.data);
            if (wr_i.addr == WIPER1_LOC) w1_q <= wr_i.data;
        end
    end

    always_comb begin
        if (rd_addr_i <= USER_LAST)       rd_data_o = user_mem[rd_addr_i];
        else if (rd_addr_i == WIPER0_LOC) rd_data_o = w0_q;
        else if (rd_addr_i == WIPER1_LOC) rd_data_o = w1_q;
        else                              rd_data_o = '0;
    end

    assign wiper0_o = w0_q;
    assign wiper1_o = w1_q;
endmodule

// File: rtl/pot_mem_top.sv
module pot_mem_top
    import pot_mem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i,
    output logic               sda_oe_o,
    output logic [BYTE_W-1:0]  wiper0_o,
    output logic [BYTE_W-1:0]  wiper1_o
);
    line_evt_t         evt;
    wr_req_t           wr_req;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              protect;

    // Only a definite 0 unlocks writes; X or Z behave like the pull-up.
    assign protect = (wp_i === 1'b0) ? 1'b0 : 1'b1;

    pot_mem_line_sync #(.SYNC_STAGES(2)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt_o(evt)
    );

    pot_mem_link link_i (
        .clk(clk), .rst(rst), .evt_i(evt), .strap_i(strap_i),
        .rd_data_i(rd_data), .sda_oe_o(sda_oe_o), .ptr_o(ptr), .wr_o(wr_req)
    );

    pot_mem_array array_i (
        .clk(clk), .rst(rst), .protect_i(protect), .wr_i(wr_req),
        .rd_addr_i(ptr), .rd_data_o(rd_data),
        .wiper0_o(wiper0_o), .wiper1_o(wiper1_o)
    );
endmodule

// File: rtl/pot_mem_chk.sv
module pot_mem_chk
    import pot_mem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_fall,
    input logic              stop,
    input logic              protect,
    input link_state_e       state,
    input logic [BYTE_W-1:0] wiper0,
    input logic [BYTE_W-1:0] wiper1
);
    a_r1_ack_held: assert property (@(posedge clk) disable iff (rst)
        state == ST_ADDR_ACK |-> sda_oe);

    a_r2_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    a_r7_wiper0_limit: assert property (@(posedge clk) disable iff (rst)
        wiper0 <= WIPER0_MAX);

    a_r9_wipers_frozen: assert property (@(posedge clk) disable iff (rst)
        protect |=> $stable(wiper0) && $stable(wiper1));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !sda_oe);

    a_r11_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop |=> state == ST_IDLE && !sda_oe);

    a_r12_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> wiper0 == '0 && wiper1 == '0 && !sda_oe);
endmodule

bind pot_mem_top pot_mem_chk chk_i (
    .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .scl_fall(evt.scl_fall),
    .stop(evt.stop), .protect(protect), .state(link_i.state),
    .wiper0(wiper0_o), .wiper1(wiper1_o)
);

// File: tb/pot_mem_top_tb.sv
module pot_mem_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] DEV = {4'b1010, STRAP};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [7:0] wiper0, wiper1;
    int checks = 0;
    int errors = 0;
    logic [7:0] rbuf [4];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    pot_mem_top dut_i (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe),
        .wiper0_o(wiper0), .wiper1_o(wiper1)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic seen);
        tick(Q); m_low = ~b;
        tick(Q); m_scl = 1'b1;
        tick(Q); seen = sda_line;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        tick(Q); m_low = 1'b0;
        tick(Q); m_scl = 1'b1;
        tick(Q); b = sda_line;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); m_low = 1'b0;
        tick(Q); m_scl = 1'b1;
        tick(Q); m_low = 1'b1;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_low = 1'b1;
        tick(Q); m_scl = 1'b1;
        tick(Q); m_low = 1'b0;
        tick(Q);
    endtask

    // R2: each bit the master sends must appear on the line unchanged
    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic seen, a;
        logic [7:0] line_bits;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], seen);
            line_bits[i] = seen;
        end
        check("R2 line follows master", line_bits, b);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        logic seen;
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(~give_ack, seen);
    endtask

    task automatic bus_write(input logic [7:0] p, input logic [7:0] d0,
                             input logic [7:0] d1, input int n);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b0}, ack); check("R1 addr ack", {7'd0, ack}, 8'd1);
        wr_byte(p, ack);           check("R3 ptr ack", {7'd0, ack}, 8'd1);
        if (n > 0) begin wr_byte(d0, ack); check("R9 data ack", {7'd0, ack}, 8'd1); end
        if (n > 1) begin wr_byte(d1, ack); check("R9 data ack", {7'd0, ack}, 8'd1); end
        bus_stop();
    endtask

    task automatic bus_read(input logic [7:0] p, input int n);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(p, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, ack); check("R4 read addr ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) rd_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        rd_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R12 wiper0 reset", wiper0, 8'h00);
        check("R12 wiper1 reset", wiper1, 8'h00);
        check("R12 sda released", {7'd0, sda_line}, 8'd1);
    endtask

    task automatic t_address();
        logic ack;
        bus_start();
        wr_byte({4'b1010, 3'b100, 1'b0}, ack);
        check("R1 wrong strap no ack", {7'd0, ack}, 8'd0);
        bus_stop();
        bus_start();
        wr_byte({4'b1011, STRAP, 1'b0}, ack);
        check("R1 wrong family no ack", {7'd0, ack}, 8'd0);
        wr_byte(8'h00, ack);
        check("R1 ignored until start", {7'd0, ack}, 8'd0);
        bus_stop();
    endtask

    task automatic t_seq_rw();
        bus_write(8'h10, 8'h11, 8'hB2, 2);
        bus_write(8'h12, 8'h3C, 8'h00, 1);
        bus_read(8'h10, 3);
        check("R3 R4 byte 10", rbuf[0], 8'h11);
        check("R3 R4 byte 11", rbuf[1], 8'hB2);
        check("R4 byte 12", rbuf[2], 8'h3C);
    endtask

    task automatic t_wrap();
        bus_write(8'hFF, 8'h11, 8'hA5, 2);
        bus_read(8'hFF, 2);
        check("R5 FF reads zero", rbuf[0], 8'h00);
        check("R5 wrapped to 00", rbuf[1], 8'hA5);
    endtask

    task automatic t_wiper();
        bus_write(8'hF8, 8'hC8, 8'h42, 2);
        check("R6 wiper1", wiper1, 8'hC8);
        check("R6 wiper0", wiper0, 8'h42);
        bus_read(8'hF8, 2);
        check("R6 F8 readback", rbuf[0], 8'hC8);
        check("R6 F9 readback", rbuf[1], 8'h42);
        bus_write(8'hF9, 8'hFF, 8'h00, 1);
        check("R7 clamp FF", wiper0, 8'h63);
        bus_write(8'hF9, 8'h64, 8'h00, 1);
        check("R7 clamp 64", wiper0, 8'h63);
        bus_write(8'hF9, 8'h62, 8'h00, 1);
        check("R7 below limit", wiper0, 8'h62);
        bus_write(8'hF9, 8'h63, 8'h00, 1);
        bus_read(8'hF9, 1);
        check("R7 readback at limit", rbuf[0], 8'h63);
    endtask

    task automatic t_reserved();
        bus_write(8'hFA, 8'h77, 8'h88, 2);
        bus_read(8'hFA, 2);
        check("R8 FA zero", rbuf[0], 8'h00);
        check("R8 FB zero", rbuf[1], 8'h00);
        check("R8 wiper0 kept", wiper0, 8'h63);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        bus_write(8'h20, 8'h3C, 8'h4D, 2);
        bus_write(8'h22, 8'h5E, 8'h00, 1);
        wp = 1'b1;
        bus_write(8'h20, 8'hEE, 8'hEE, 2);
        bus_write(8'hF8, 8'h11, 8'h12, 2);
        check("R9 wiper1 frozen", wiper1, 8'hC8);
        check("R9 wiper0 frozen", wiper0, 8'h63);
        bus_write(8'h20, 8'hEE, 8'hEE, 2);
        wp = 1'b0;
        cur_read(d);
        check("R9 pointer advanced", d, 8'h5E);
        bus_read(8'h20, 2);
        check("R9 byte 20 kept", rbuf[0], 8'h3C);
        check("R9 byte 21 kept", rbuf[1], 8'h4D);
    endtask

    task automatic t_nack();
        logic ack, b;
        logic [7:0] d;
        logic any_low;
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h10, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        rd_byte(1'b0, d);
        check("R10 read before nack", d, 8'h11);
        any_low = 1'b0;
        for (int i = 0; i < 9; i++) begin
            recv_bit(b);
            if (!b) any_low = 1'b1;
        end
        check("R10 quiet after nack", {7'd0, any_low}, 8'd0);
        bus_stop();
        check("R11 released after stop", {7'd0, sda_line}, 8'd1);
        bus_write(8'h30, 8'h00, 8'h00, 0);
    endtask

    task automatic t_reset_ptr();
        logic [7:0] d;
        bus_write(8'h00, 8'h5A, 8'h00, 1);
        bus_write(8'h40, 8'h00, 8'h00, 0);
        tick(2); rst = 1'b1;
        tick(3); rst = 1'b0;
        tick(2);
        check("R12 wiper0 after reset", wiper0, 8'h00);
        check("R12 wiper1 after reset", wiper1, 8'h00);
        cur_read(d);
        check("R12 pointer cleared", d, 8'h5A);
    endtask

    initial begin
        tick(5); rst = 1'b0;
        tick(5);
        t_reset();
        t_address();
        t_seq_rw();
        t_wrap();
        t_wiper();
        t_reserved();
        t_protect();
        t_nack();
        t_reset_ptr();
        tick(10);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule